// File: doc/BRIEF.md
# Parallel Pseudo-Random Pattern Checker with Framing Hold

This block receives sixteen independent one-bit lanes, one bit per lane on each accepted beat, and checks each lane against a seven-stage pseudo-random sequence with feedback polynomial x^7 + x^6 + 1. Every lane has its own reference generator. A load command takes the newest seven received bits of each lane as the seed, so the reference locks onto whatever phase the stream is in. From then on the reference runs freely, and each received bit that differs from the reference bit is one error.

Per beat the block reports the number of wrong bits across all lanes, from 0 to 16. Several wrong bits in the same beat each count once, so they add up rather than collapse into one. When framing is enabled, each lane looks for a run of overhead bytes that replaces the pattern: three copies of 0xF6 followed by three copies of 0x28. The bits of those bytes are kept out of the count. The reference keeps advancing through them, so checking picks up again in phase as soon as the pattern returns. Only the default checking mode counts errors. The static-level mode, the square-wave mode and the reserved mode report zero.

Internally each lane's mismatch flags pass through a one-byte delay line. This gives the framing detector enough time to see a complete byte before the flags for its first bit are counted.

Top module: `prbs_lane_checker`

## Requirements
- R1: While reset is asserted, and after reset until the first load, `err_valid_o` is 0 and `err_cnt_o` is 0.
- R2: A beat with `din_valid_i` and `load_i` both high seeds each lane's reference from that lane's bits of that beat and the six beats before it. The load beat itself is never counted. Each later beat n is compared with b[n-7] XOR b[n-6], extended from the seed.
- R3: The count is the number of lanes whose bit mismatches. Three wrong lanes in a beat give 3, and all sixteen wrong give 16. The count never exceeds 16.
- R4: After the first load, every accepted beat produces `err_valid_o` high in the following cycle. The count carried with valid beat j covers the bits received on accepted beat j-8.
- R5: A cycle with `din_valid_i` low advances nothing. It produces `err_valid_o` low in the next cycle, and `err_cnt_o` keeps its value. The data on `din_i` in such a cycle has no effect.
- R6: With `frame_en_i` high, a lane that is searching starts a hold when its last eight bits, oldest first, equal 0xF6. The bits of that byte are not counted.
- R7: During a hold, each following byte-aligned group of eight bits is compared in order with 0xF6, 0xF6, 0x28, 0x28, 0x28. A matching group is excluded from the count. A mismatching group is counted and returns the lane to searching. The hold ends after the third 0x28.
- R8: With `frame_en_i` low there is no hold. Framing bytes in the stream are counted as ordinary mismatches.
- R9: `mode_i` 2'b00 checks the pattern. 2'b01 (static level), 2'b10 (square wave) and 2'b11 (reserved) report a count of 0 while `err_valid_o` still strobes.
- R10: Lanes are independent. A hold on one lane never hides mismatches on another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din_valid_i | input | 1 | Beat accept; all lanes advance when high |
| din_i | input | LANES | One received bit per lane |
| load_i | input | 1 | Seed the references from the received bits on this beat |
| mode_i | input | 2 | 00 check, 01 static, 10 square, 11 reserved |
| frame_en_i | input | 1 | Enables the framing-byte hold |
| err_valid_o | output | 1 | Count strobe, one cycle after each accepted beat once loaded |
| err_cnt_o | output | $clog2(LANES+1) | Mismatching bits in the reported beat |

## Verification
The hardest case to reach from the ports is a hold that stops partway. This happens when a lane has already matched one or more framing bytes and then a later byte in the run breaks. The bytes matched so far must stay excluded, and the broken byte must be counted. The bench produces this in two ways. It writes only two 0xF6 bytes into one lane, and it flips a bit inside the third 0x28 byte of another lane. Random bit flips also land inside complete framing runs. Expected counts come from a bench-side scan of each lane's bit array, and the same scan also catches 0xF6 bytes that appear by chance inside the pseudo-random pattern. Random idle cycles are spread between beats to show that the byte alignment of the hold follows accepted beats and not clock cycles.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

  // Width of one overhead byte; also the depth of the mismatch delay line.
  localparam int FRM_W = 8;

  localparam logic [FRM_W-1:0] FRM_A1 = 8'hF6;
  localparam logic [FRM_W-1:0] FRM_A2 = 8'h28;

  typedef enum logic [1:0] {
    MD_PRBS   = 2'b00,
    MD_STATIC = 2'b01,
    MD_SQUARE = 2'b10,
    MD_RSVD   = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    FS_SEARCH = 3'd0,
    FS_A1B    = 3'd1,
    FS_A1C    = 3'd2,
    FS_A2A    = 3'd3,
    FS_A2B    = 3'd4,
    FS_A2C    = 3'd5
  } fstate_e;

endpackage

// File: rtl/pchk_rst_sync.sv
module pchk_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/pchk_popcnt.sv
module pchk_popcnt #(
  parameter int N = 16,
  parameter int W = 5
) (
  input  logic [N-1:0] bits_i,
  output logic [W-1:0] sum_o
);

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N; i++) begin
      sum_o = sum_o + W'(bits_i[i]);
    end
  end

endmodule

// File: rtl/pchk_lane.sv
module pchk_lane
  import pchk_pkg::*;
#(
  parameter int ORDER = 7,
  parameter int TAP   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  logic bit_i,
  input  logic load_i,
  input  logic lock_i,
  input  logic chk_en_i,
  input  logic frame_en_i,
  output logic flag_o,
  output logic hold_o
);

  localparam int BW = FRM_W;
  localparam int HW = $clog2(BW + 1);
  localparam int CW = $clog2(BW);

  logic [BW-1:0]    win_q, win_nx;
  logic [ORDER-1:0] ref_q, ref_d;
  logic [BW-1:0]    dly_q, dly_d;
  logic [HW-1:0]    hold_q, hold_d;
  logic [CW-1:0]    bc_q, bc_d;
  fstate_e          fst_q, fst_d;
  logic             exp_bit, mis;
  logic [BW-1:0]    want;

  // Reference step and compare
  always_comb begin
    win_nx  = {win_q[BW-2:0], bit_i};
    exp_bit = ref_q[ORDER-1] ^ ref_q[TAP-1];
    mis     = lock_i & chk_en_i & ~load_i & (bit_i ^ exp_bit);
    ref_d   = load_i ? win_nx[ORDER-1:0] : {ref_q[ORDER-2:0], exp_bit};
    dly_d   = {dly_q[BW-2:0], mis};
  end

  // Framing detector next state
  always_comb begin
    want   = ((fst_q == FS_A1B) || (fst_q == FS_A1C)) ? FRM_A1 : FRM_A2;
    fst_d  = fst_q;
    bc_d   = bc_q;
    hold_d = hold_q;
    if (adv_i) begin
      hold_d = (hold_q != '0) ? hold_q - HW'(1) : '0;
      if (fst_q == FS_SEARCH) begin
        if (win_nx == FRM_A1) begin
          fst_d  = FS_A1B;
          bc_d   = '0;
          hold_d = HW'(BW);
        end
      end else if (bc_q == CW'(BW - 1)) begin
        bc_d = '0;
        if (win_nx == want) begin
          hold_d = HW'(BW);
          fst_d  = (fst_q == FS_A2C) ? FS_SEARCH : fstate_e'(fst_q + 3'd1);
        end else begin
          fst_d = FS_SEARCH;
        end
      end else begin
        bc_d = bc_q + CW'(1);
      end
    end
    if (!frame_en_i) begin
      fst_d  = FS_SEARCH;
      bc_d   = '0;
      hold_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      ref_q <= '0;
      dly_q <= '0;
    end else if (adv_i) begin
      win_q <= win_nx;
      ref_q <= ref_d;
      dly_q <= dly_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst_q  <= FS_SEARCH;
      bc_q   <= '0;
      hold_q <= '0;
    end else begin
      fst_q  <= fst_d;
      bc_q   <= bc_d;
      hold_q <= hold_d;
    end
  end

  assign flag_o = dly_q[BW-1] & (hold_q == '0);
  assign hold_o = (hold_q != '0);

endmodule

// File: rtl/prbs_lane_checker.sv
module prbs_lane_checker
  import pchk_pkg::*;
#(
  parameter int LANES = 16,
  parameter int ORDER = 7,
  parameter int TAP   = 6,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             din_valid_i,
  input  logic [LANES-1:0] din_i,
  input  logic             load_i,
  input  logic [1:0]       mode_i,
  input  logic             frame_en_i,
  output logic             err_valid_o,
  output logic [CNT_W-1:0] err_cnt_o
);

  logic             rst_n;
  logic             lk_q, lk_d;
  logic             chk_en;
  logic [LANES-1:0] flag_v, hold_v;
  logic [CNT_W-1:0] pop, cnt_d, cnt_q;
  logic             vld_d, vld_q;

  pchk_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  assign chk_en = (mode_e'(mode_i) == MD_PRBS);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pchk_lane #(.ORDER(ORDER), .TAP(TAP)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv_i      (din_valid_i),
      .bit_i      (din_i[g]),
      .load_i     (load_i),
      .lock_i     (lk_q),
      .chk_en_i   (chk_en),
      .frame_en_i (frame_en_i),
      .flag_o     (flag_v[g]),
      .hold_o     (hold_v[g])
    );
  end

  pchk_popcnt #(.N(LANES), .W(CNT_W)) u_pop (
    .bits_i (flag_v),
    .sum_o  (pop)
  );

  always_comb begin
    lk_d  = lk_q | (din_valid_i & load_i);
    vld_d = din_valid_i & lk_q;
    cnt_d = chk_en ? pop : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_q  <= 1'b0;
      vld_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lk_q  <= lk_d;
      vld_q <= vld_d;
      if (din_valid_i) cnt_q <= cnt_d;
    end
  end

  assign err_valid_o = vld_q;
  assign err_cnt_o   = cnt_q;

endmodule

// File: rtl/pchk_sva.sv
module pchk_sva #(
  parameter int LANES = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             din_valid_i,
  input logic [1:0]       mode_i,
  input logic             frame_en_i,
  input logic             lk_q,
  input logic [LANES-1:0] hold_v,
  input logic             err_valid_o,
  input logic [CNT_W-1:0] err_cnt_o
);

  a_r5_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !din_valid_i |=> !err_valid_o);

  a_r1_no_strobe_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_q |=> !err_valid_o);

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid_o |-> (32'(err_cnt_o) <= LANES));

  a_r9_unsupported_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid_i && (mode_i != 2'b00)) |=> (err_cnt_o == '0));

  a_r8_no_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_en_i |=> (hold_v == '0));

endmodule

bind prbs_lane_checker pchk_sva #(.LANES(LANES), .CNT_W(CNT_W)) sva_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .din_valid_i (din_valid_i),
  .mode_i      (mode_i),
  .frame_en_i  (frame_en_i),
  .lk_q        (lk_q),
  .hold_v      (hold_v),
  .err_valid_o (err_valid_o),
  .err_cnt_o   (err_cnt_o)
);

// File: tb/prbs_lane_checker_tb_top.sv
module prbs_lane_checker_tb_top;

  localparam int LN = 16;
  localparam int CW = 5;
  localparam int T  = 360;
  localparam int LD = 10;
  localparam int RL = 250;

  logic          clk;
  logic          arst_n;
  logic          din_valid_i;
  logic [LN-1:0] din_i;
  logic          load_i;
  logic [1:0]    mode_i;
  logic          frame_en_i;
  logic          err_valid_o;
  logic [CW-1:0] err_cnt_o;

  int nchk, nbad, cyc;
  logic [LN-1:0] patw [T];
  logic [LN-1:0] strm [T];
  logic [LN-1:0] mskw [T];
  int unsigned   lcg;

  prbs_lane_checker dut_i (
    .clk(clk), .arst_n(arst_n), .din_valid_i(din_valid_i), .din_i(din_i),
    .load_i(load_i), .mode_i(mode_i), .frame_en_i(frame_en_i),
    .err_valid_o(err_valid_o), .err_cnt_o(err_cnt_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int unsigned rnd();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >> 8);
  endfunction

  task automatic chk(string tag, bit ok, int act, int expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic put_byte(int l, int t0, logic [7:0] b);
    for (int i = 0; i < 8; i++) strm[t0+i][l] = b[7-i];
  endtask

  // Build reference pattern, stream with injected faults and the framing mask
  task automatic build(bit errs, bit frames, bit fen);
    for (int l = 0; l < LN; l++) begin
      logic [6:0] sd;
      sd = 7'((l * 37 + 5) % 127 + 1);
      for (int t = 0; t < T; t++)
        patw[t][l] = (t < 7) ? sd[t] : (patw[t-7][l] ^ patw[t-6][l]);
    end
    for (int t = 0; t < T; t++) begin
      strm[t] = patw[t];
      mskw[t] = '0;
    end
    if (errs) begin
      strm[50] ^= 16'h0212;   // R3: three wrong lanes
      strm[60] ^= 16'hFFFF;   // R3: all lanes wrong
      for (int t = 20; t < 240; t++)
        if (rnd() % 11 == 0) strm[t][rnd() % LN] ^= 1'b1;
    end
    if (frames) begin
      for (int l = 0; l < LN; l += 2) begin
        for (int k = 0; k < 3; k++) put_byte(l, 100 + 8*k, 8'hF6);
        for (int k = 3; k < 6; k++) put_byte(l, 100 + 8*k, 8'h28);
      end
      strm[142][6] ^= 1'b1;            // R7: break third A2 on lane 6
      put_byte(3, 180, 8'hF6);          // R7: partial run on lane 3
      put_byte(3, 188, 8'hF6);
    end
    if (fen) begin
      for (int l = 0; l < LN; l++) begin
        int st, bc;
        logic [7:0] w;
        st = 0; bc = 0; w = '0;
        for (int t = 0; t < T; t++) begin
          w = {w[6:0], strm[t][l]};
          if (st == 0) begin
            if (w == 8'hF6) begin
              for (int i = 0; i < 8; i++) mskw[t-i][l] = 1'b1;
              st = 1; bc = 0;
            end
          end else if (bc == 7) begin
            bc = 0;
            if (w == ((st <= 2) ? 8'hF6 : 8'h28)) begin
              for (int i = 0; i < 8; i++) mskw[t-i][l] = 1'b1;
              st = (st == 5) ? 0 : st + 1;
            end else st = 0;
          end else bc++;
        end
      end
    end
  endtask

  function automatic int exp_cnt(int j, int md, bit rl);
    int k, s;
    if (j < 8) return 0;
    k = j - 8;
    if (k <= LD || md != 0 || (rl && k == RL)) return 0;
    s = 0;
    for (int l = 0; l < LN; l++)
      s += int'((strm[k][l] ^ patw[k][l]) & ~mskw[k][l]);
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    arst_n = 1'b0; din_valid_i = 1'b0; load_i = 1'b0; din_i = '0;
    repeat (2) @(negedge clk);
    chk("R1 reset valid", err_valid_o == 1'b0, err_valid_o, 0);
    chk("R1 reset count", err_cnt_o == '0, err_cnt_o, 0);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_case(string tag, int md, bit fen, bit errs, bit frames,
                          bit gaps, bit rl);
    int held;
    build(errs, frames, fen);
    mode_i = 2'(md); frame_en_i = fen;
    do_reset();
    held = 0;
    for (int t = 0; t < T; t++) begin
      if (gaps && (rnd() % 4 == 0)) begin
        @(negedge clk);
        din_valid_i = 1'b0; load_i = 1'b1; din_i = ~strm[t];
        @(posedge clk); #1;
        chk("R5 idle strobe", err_valid_o == 1'b0, err_valid_o, 0);
        chk("R5 idle hold", int'(err_cnt_o) == held, err_cnt_o, held);
      end
      @(negedge clk);
      din_valid_i = 1'b1; din_i = strm[t];
      load_i = (t == LD) || (rl && t == RL);
      @(posedge clk); #1;
      // R4: strobe follows every accepted beat after the first load
      if (t <= LD) begin
        chk("R1 no strobe before load", err_valid_o == 1'b0, err_valid_o, 0);
      end else begin
        int e;
        string tg;
        e = exp_cnt(t, md, rl);
        tg = tag;
        if (t == 58 || t == 68) tg = "R3";
        else if (fen && t >= 108 && t < 156) tg = "R6";
        chk("R4 strobe", err_valid_o == 1'b1, err_valid_o, 1);
        chk(tg, int'(err_cnt_o) == e, err_cnt_o, e);
      end
      held = int'(err_cnt_o);
    end
    @(negedge clk);
    din_valid_i = 1'b0; load_i = 1'b0;
  endtask

  initial begin
    nchk = 0; nbad = 0; cyc = 0; lcg = 32'h1234_5678;
    arst_n = 1'b0; din_valid_i = 1'b0; load_i = 1'b0; din_i = '0;
    mode_i = 2'b00; frame_en_i = 1'b0;
    run_case("R2", 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1); // seeding, reload
    run_case("R8", 0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); // framing counted
    run_case("R7", 0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // hold and aborts
    run_case("R10", 0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); // lanes independent
    run_case("R9", 1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_case("R9", 2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    run_case("R9", 3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    nchk++; nbad++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule